// File: doc/BRIEF.md
# Register-Driven Serial Word Transmitter

This block is a transmit-only serial peripheral master. It sends one 16-bit word to a single attached slave device, such as an audio codec, for each transfer. Software controls it through three 32-bit word registers on a simple register port. A write places the outgoing word. A level-style start bit launches the word. A busy flag shows when the frame is done.

Every frame uses clock-idle-low, rising-edge-sample timing. The word goes out most significant bit first. The active-low select line is lowered and raised by the block itself around every word. A parameter sets the serial clock half-period in system clock cycles. Software sets start to 1, polls busy until it reads 0, and then clears start to 0 before the next word.

Top module: `spi_tx_master`

## Requirements
- R1: After reset, csN is 1, sclk is 0, and both the start register (offset 0x0, bit 0) and the busy register (offset 0x4, bit 0) read 0.
- R2: A write of bit 0 = 1 to offset 0x0 while start reads 0 and no frame is active launches a frame. csN falls at that same clock edge, and busy reads 1 from the next cycle. No other event lowers csN.
- R3: Each frame produces exactly 16 rising sclk edges. At the k-th rising edge (k = 0..15), mosi equals bit 15-k of the last value written to offset 0x8. Bits 31:16 of that write have no effect on the frame.
- R4: Mode 0 timing holds: sclk is 0 whenever csN is 1, and mosi does not change while sclk stays high.
- R5: The first rising sclk edge comes HALF_DIV cycles after csN falls. csN rises HALF_DIV cycles after the last falling sclk edge. The whole frame spans 33*HALF_DIV cycles.
- R6: Busy reads 1 exactly while csN is 0, so busy clears at the edge that raises csN.
- R7: While start reads 1, neither holding it nor writing 1 again starts another frame. Only a new 0-to-1 write does.
- R8: A write to offset 0x8 while busy is 1 is ignored. The next frame sends the word that was present before that write.
- R9: Reading offset 0x8 returns 0 because no receive path exists. Offset 0x0 returns the start bit in bit 0.
- R10: sclk changes only while csN is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWe | input | 1 | Write enable, one cycle per write |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Combinational read data for regAddr |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out, most significant bit first |
| csN | output | 1 | Active-low slave select, framed per word |

## Verification
The bench builds the block with HALF_DIV = 2, so each frame lasts 66 cycles. This short frame lets the bench run a full walking-one sweep over all 16 data bit positions, plus fixed patterns and several dozen pseudo-random words with random upper bits, within a small run time. The small divider also brings the exact lead, trail and frame lengths into easy reach for cycle-accurate checks. The same run covers relaunch suppression while start stays high and data writes made in the middle of a frame.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
  localparam int START_OFS = 0;
  localparam int BUSY_OFS  = 4;
  localparam int DATA_OFS  = 8;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;      // capture word, lower select
    logic sclkRise;  // drive sclk high
    logic sclkFall;  // drive sclk low and advance shift register
    logic frameEnd;  // raise select
  } txStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL
  } txState_t;
endpackage

// File: rtl/spi_tx_ctrl.sv
module spi_tx_ctrl
  import spi_tx_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int WORD_W   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startRise,
  input  logic       sclkLevel,
  output txStrobes_t strobes,
  output logic       busy
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(WORD_W - 1);

  txState_t         state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             tick;

  assign tick = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          divCnt <= '0;
          if (startRise) begin
            state  <= ST_LEAD;
            bitCnt <= '0;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            divCnt <= '0;
            state  <= ST_SHIFT;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            divCnt <= '0;
            if (sclkLevel) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == BIT_LAST) state <= ST_TRAIL;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            divCnt <= '0;
            state  <= ST_IDLE;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.load     = (state == ST_IDLE) && startRise;
    strobes.sclkRise = tick && ((state == ST_LEAD) || ((state == ST_SHIFT) && !sclkLevel));
    strobes.sclkFall = tick && (state == ST_SHIFT) && sclkLevel;
    strobes.frameEnd = tick && (state == ST_TRAIL);
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/spi_tx_datapath.sv
module spi_tx_datapath
  import spi_tx_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              busy,
  input  txStrobes_t        strobes,
  output logic [DATA_W-1:0] regRdata,
  output logic              startRise,
  output logic              sclk,
  output logic              mosi,
  output logic              csN
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_START = IDX_W'(START_OFS / 4);
  localparam logic [IDX_W-1:0] IDX_BUSY  = IDX_W'(BUSY_OFS / 4);
  localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(DATA_OFS / 4);

  logic              startReg;
  logic [WORD_W-1:0] dataReg;
  logic [WORD_W-1:0] shiftReg;
  logic              aligned;
  logic [IDX_W-1:0]  wordIdx;
  logic              wrStart;
  logic              wrData;

  assign aligned   = (regAddr[1:0] == 2'b00);
  assign wordIdx   = regAddr[ADDR_W-1:2];
  assign wrStart   = regWe && aligned && (wordIdx == IDX_START);
  assign wrData    = regWe && aligned && (wordIdx == IDX_DATA);
  assign startRise = wrStart && regWdata[0] && !startReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startReg <= 1'b0;
      dataReg  <= '0;
    end else begin
      if (wrStart) startReg <= regWdata[0];
      if (wrData && !busy) dataReg <= regWdata[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sclk     <= 1'b0;
      csN      <= 1'b1;
    end else begin
      if (strobes.load) begin
        shiftReg <= dataReg;
        csN      <= 1'b0;
      end
      if (strobes.sclkRise) sclk <= 1'b1;
      if (strobes.sclkFall) begin
        sclk     <= 1'b0;
        shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
      end
      if (strobes.frameEnd) csN <= 1'b1;
    end
  end

  assign mosi = shiftReg[WORD_W-1];

  always_comb begin
    regRdata = '0;
    if (aligned) begin
      if (wordIdx == IDX_START)     regRdata[0] = startReg;
      else if (wordIdx == IDX_BUSY) regRdata[0] = busy;
    end
  end
endmodule

// File: rtl/spi_tx_master.sv
module spi_tx_master
  import spi_tx_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int WORD_W   = 16,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              sclk,
  output logic              mosi,
  output logic              csN
);
  txStrobes_t strobes;
  logic       busy;
  logic       startRise;

  spi_tx_ctrl #(.HALF_DIV(HALF_DIV), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startRise(startRise), .sclkLevel(sclk),
    .strobes(strobes), .busy(busy)
  );

  spi_tx_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .busy(busy), .strobes(strobes), .regRdata(regRdata), .startRise(startRise),
    .sclk(sclk), .mosi(mosi), .csN(csN)
  );
endmodule

// File: rtl/spi_tx_checker.sv
module spi_tx_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              sclk,
  input logic              mosi,
  input logic              csN
);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_BUSY  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(8);

  assert_sclk_idle_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_busy_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_BUSY) |-> (regRdata[0] == !csN));

  assert_data_read_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_DATA) |-> (regRdata == '0));

  assert_launch_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(regWe && (regAddr == A_START) && regWdata[0]));

  assert_clk_in_frame_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclk) |-> !csN);
endmodule

bind spi_tx_master spi_tx_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
  .regRdata(regRdata), .sclk(sclk), .mosi(mosi), .csN(csN)
);

// File: tb/tb_spi_tx_master.sv
module tb_spi_tx_master;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int H      = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWe = 1'b0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic              sclk, mosi, csN;

  always #10 clk = ~clk;  // 50 MHz

  spi_tx_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(16), .HALF_DIV(H)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .sclk(sclk), .mosi(mosi), .csN(csN)
  );

  int total = 0;
  int fails = 0;
  bit finished = 0;

  // frame monitor, sampled away from the active edge
  int          cyc = 0;
  int          fallCyc = 0, firstRise = 0, lastFall = 0, csRiseCyc = 0;
  int          rises = 0, frames = 0;
  logic [15:0] cap = '0;
  logic        prevCs = 1'b1, prevSclk = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (prevCs && !csN) begin
      fallCyc <= cyc; rises <= 0; cap <= '0; frames <= frames + 1;
    end
    if (!prevSclk && sclk) begin
      if (!(prevCs && !csN)) begin
        if (rises == 0) firstRise <= cyc;
        cap   <= {cap[14:0], mosi};
        rises <= rises + 1;
      end
    end
    if (prevSclk && !sclk) lastFall <= cyc;
    if (!prevCs && csN) csRiseCyc <= cyc;
    prevCs   <= csN;
    prevSclk <= sclk;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    regAddr = ADDR_W'(addr); regWdata = data; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic busRead(input int addr, output logic [31:0] data);
    regAddr = ADDR_W'(addr);
    #1 data = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] r;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      busRead(4, r);
      if (r[0] == 1'b0) break;
    end
  endtask

  // start a frame with data already loaded, then check the whole frame
  task automatic runFrame(input logic [15:0] expWord, input string tag);
    logic [31:0] r;
    busWrite(0, 32'h1);
    busRead(4, r);
    check(r[0] == 1'b1, "R2 busy after start", r, 32'h1);
    waitIdle();
    #2;
    check(cap == expWord, tag, {16'h0, cap}, {16'h0, expWord});
    check(rises == 16, "R3 rising edge count", rises, 16);
    check(firstRise - fallCyc == H, "R5 lead time", firstRise - fallCyc, H);
    check(csRiseCyc - lastFall == H, "R5 trail time", csRiseCyc - lastFall, H);
    check(csRiseCyc - fallCyc == 33 * H, "R5 frame length", csRiseCyc - fallCyc, 33 * H);
    check(csN == 1'b1 && sclk == 1'b0, "R6 idle after busy clears", {csN, sclk}, 2'b10);
  endtask

  task automatic sendWord(input logic [15:0] w, input logic [15:0] junk);
    busWrite(8, {junk, w});
    runFrame(w, "R3 word shifted msb first");
    busWrite(0, 32'h0);
  endtask

  initial begin
    logic [31:0] r;
    logic [31:0] seed;
    int fr;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    busRead(0, r);
    check(csN == 1'b1 && sclk == 1'b0, "R1 pins in reset", {csN, sclk}, 2'b10);
    rstN = 1'b1;
    @(negedge clk);
    busRead(0, r); check(r == 0, "R1 start reads 0", r, 0);
    busRead(4, r); check(r == 0, "R1 busy reads 0", r, 0);
    check(csN == 1'b1 && sclk == 1'b0, "R1 pins after reset", {csN, sclk}, 2'b10);

    // R3 walking ones and fixed patterns
    for (int b = 0; b < 16; b++) sendWord(16'(1 << b), 16'hFFFF);
    sendWord(16'h0000, 16'hDEAD);
    sendWord(16'hFFFF, 16'h0000);
    sendWord(16'hA5A5, 16'h5A5A);
    sendWord(16'h5A5A, 16'hA5A5);
    for (int n = 0; n < 40; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      sendWord(seed[30:15], seed[15:0]);
    end

    // R9 read-back of start and data
    busWrite(8, 32'hFFFF_FFFF);
    busRead(8, r); check(r == 0, "R9 data reads 0", r, 0);
    busWrite(0, 32'h1);
    busRead(0, r); check(r == 1, "R9 start reads 1", r, 1);
    waitIdle();

    // R7 hold start high and rewrite 1: no new frame
    fr = frames;
    repeat (10 * H) @(negedge clk);
    busWrite(0, 32'h1);
    repeat (10 * H) @(negedge clk);
    check(frames == fr, "R7 no relaunch while start high", frames, fr);
    check(csN == 1'b1, "R7 select stays high", csN, 1);
    busWrite(0, 32'h0);

    // R8 data write during busy is ignored
    busWrite(8, 32'h0000_C3A1);
    busWrite(0, 32'h1);
    busWrite(8, 32'h0000_1234);
    waitIdle();
    #2;
    check(cap == 16'hC3A1, "R8 frame unchanged by mid-frame write", cap, 16'hC3A1);
    busWrite(0, 32'h0);
    runFrame(16'hC3A1, "R8 stored word unchanged");
    busWrite(0, 32'h0);

    // R10 quiet bus: sclk stays low
    repeat (5 * H) @(negedge clk);
    check(sclk == 1'b0 && csN == 1'b1, "R10 sclk quiet outside frame", {csN, sclk}, 2'b10);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule